// File: doc/BRIEF.md
# Thirteen-Pin GPIO Controller with Edge Interrupts

The block gives a host thirteen general-purpose pins behind a byte-wide register bus with a 16-bit address. Each pin has two registers. The drive register sets direction, driver type, pull resistor and output value. The sense register reports the synchronized pin level and selects which edges of that pin raise an event. The pad itself is outside the block. The block only drives the control lines a pad cell needs: output value, output enable, push-pull select, pull enable and pull select.

Pin inputs pass through a two-flop synchronizer. Edge events are found by comparing each synchronized sample with the one before it. Events set sticky pending bits, which are grouped into two status registers: pins 0 to 6 in one, pins 7 to 12 in the other. Software clears a pending bit by writing 1 to it. Two mask registers, grouped the same way, gate the pending bits onto one combined interrupt line. After a clear, software can read the status again to find events that arrived in the meantime.

Top module: `gpio_edge_irq_top`

## Requirements
- R1: After reset, every drive register, sense register and status bit is 0, and every mask bit is 1. Mask group 0 reads 0x7F and mask group 1 reads 0x3F. Every pad control output and irqOut are 0.
- R2: The drive register of pin i sits at 0x4E44+i, for i from 0 to 12. Bits 5:0 are stored and read back. Bits 7:6 read as 0.
- R3: In a drive register, bit 0 drives padOutVal. Bit 1 and bit 2 drive padPullSel[2i] and padPullSel[2i+1]. Bit 3 drives padPullEn. Bit 4 drives padPushPull. The output enable padOutEn is high only when bit 5 (direction, 1 = output) is set and either bit 4 is 1 or bit 0 is 0. The bit 4 / bit 0 condition means an open-drain pin drives only a low.
- R4: The sense register of pin i sits at 0x4E51+i. Bit 0 reads the synchronized pin level, and writes to it are ignored. Bits 2:1 hold the edge mode. Bits 7:3 read as 0.
- R5: Edge mode encoding is 0 = none, 1 = falling, 2 = rising, 3 = both. A qualifying pin transition sets that pin's pending bit three clock edges after the input changes.
- R6: Pending bits of pins 0 to 6 are bits 6:0 of the group 0 status register at 0x4E0B. Pending bits of pins 7 to 12 are bits 5:0 of the group 1 status register at 0x4E0C, at bit (pin - 7).
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A later qualifying edge sets the bit again.
- R8: If an event and a write-1-clear hit the same status bit in the same cycle, the bit stays set.
- R9: Mask registers sit at 0x4E19 (pins 0 to 6) and 0x4E1A (pins 7 to 12), with the same bit layout as the status registers. irqOut is high exactly when some pending bit has its mask bit at 0. A mask bit of 1 blocks that pin.
- R10: A write to any other address, including 0x4E5E and 0x4E43, changes nothing. A read from such an address returns 0.
- R11: busRdData takes the addressed value one cycle after busRdEn is high, and holds its value while busRdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Registered read data |
| pinIn | input | 13 | Raw pin levels from the pads |
| padOutVal | output | 13 | Output value per pin |
| padOutEn | output | 13 | Output enable per pin |
| padPushPull | output | 13 | 1 = push-pull, 0 = open-drain |
| padPullEn | output | 13 | Pull resistor enable |
| padPullSel | output | 26 | Pull select, two bits per pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
The assertions assume that busWrEn and busRdEn are never high together. They also assume that a status write names a single group through its address. The stimulus meets both conditions because every bus access is made by a task that changes inputs only on the falling clock edge and raises one strobe at a time. Pin inputs are held for at least five cycles between transitions, so each edge reaches the status register before the next one. The one deliberate overlap is an event landing on the same edge as a clear, which is timed by counting the three-stage pin path.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int NUM_PINS  = 13;
  localparam int GRP0_PINS = 7;
  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;
  localparam int AW        = 16;
  localparam int DW        = 8;
  localparam int OC_W      = 6;
  localparam int MODE_W    = 2;
  localparam int PIN_IW    = $clog2(NUM_PINS);

  localparam logic [AW-1:0] OUT_BASE  = 16'h4E44;
  localparam logic [AW-1:0] IN_BASE   = 16'h4E51;
  localparam logic [AW-1:0] STAT_G0   = 16'h4E0B;
  localparam logic [AW-1:0] STAT_G1   = 16'h4E0C;
  localparam logic [AW-1:0] MASK_G0   = 16'h4E19;
  localparam logic [AW-1:0] MASK_G1   = 16'h4E1A;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DRIVE, SEL_SENSE, SEL_STAT, SEL_MASK
  } selKind_t;

  typedef struct packed {
    logic              wrDrive;
    logic              wrSense;
    logic              wrStat;
    logic              wrMask;
    logic              rdEn;
    selKind_t          rdSel;
    logic              grp;
    logic [PIN_IW-1:0] pin;
  } strobes_t;
endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic          busRdEn,
  output strobes_t      strb
);
  logic [AW-1:0] driveOff, senseOff;
  logic driveHit, senseHit, statHit, maskHit;

  always_comb begin
    driveOff = busAddr - OUT_BASE;
    senseOff = busAddr - IN_BASE;
    driveHit = driveOff < AW'(NUM_PINS);
    senseHit = senseOff < AW'(NUM_PINS);
    statHit  = (busAddr == STAT_G0) || (busAddr == STAT_G1);
    maskHit  = (busAddr == MASK_G0) || (busAddr == MASK_G1);

    strb.wrDrive = busWrEn && driveHit;
    strb.wrSense = busWrEn && senseHit;
    strb.wrStat  = busWrEn && statHit;
    strb.wrMask  = busWrEn && maskHit;
    strb.rdEn    = busRdEn;
    strb.grp     = (busAddr == STAT_G1) || (busAddr == MASK_G1);
    strb.pin     = driveHit ? driveOff[PIN_IW-1:0] : senseOff[PIN_IW-1:0];

    if (driveHit)      strb.rdSel = SEL_DRIVE;
    else if (senseHit) strb.rdSel = SEL_SENSE;
    else if (statHit)  strb.rdSel = SEL_STAT;
    else if (maskHit)  strb.rdSel = SEL_MASK;
    else               strb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strb,
  input  logic [DW-1:0]         wrData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [DW-1:0]         rdData,
  output logic                  irqOut,
  output logic [NUM_PINS-1:0]   padOutVal,
  output logic [NUM_PINS-1:0]   padOutEn,
  output logic [NUM_PINS-1:0]   padPushPull,
  output logic [NUM_PINS-1:0]   padPullEn,
  output logic [2*NUM_PINS-1:0] padPullSel,
  output logic [NUM_PINS-1:0]   statVec,
  output logic [NUM_PINS-1:0]   maskVec,
  output logic [NUM_PINS-1:0]   evtVec,
  output logic [NUM_PINS-1:0]   clrVec,
  output logic [NUM_PINS-1:0]   dirVec
);
  logic [OC_W-1:0]   driveReg [NUM_PINS];
  logic [MODE_W-1:0] edgeMode [NUM_PINS];
  logic [NUM_PINS-1:0] syncA, syncB, prevLvl;
  logic [DW-1:0] rdMux;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData[DW-1:OC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        driveReg[i] <= '0;
        edgeMode[i] <= '0;
      end else begin
        if (strb.wrDrive && strb.pin == PIN_IW'(i))
          driveReg[i] <= wrData[OC_W-1:0];
        if (strb.wrSense && strb.pin == PIN_IW'(i))
          edgeMode[i] <= wrData[MODE_W:1];
      end
    end

    assign rise      = syncB[i] & ~prevLvl[i];
    assign fall      = ~syncB[i] & prevLvl[i];
    assign evtVec[i] = (edgeMode[i][1] & rise) | (edgeMode[i][0] & fall);

    if (i < GRP0_PINS) begin : g_grp0
      assign clrVec[i] = strb.wrStat && !strb.grp && wrData[i];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) maskVec[i] <= 1'b1;
        else if (strb.wrMask && !strb.grp) maskVec[i] <= wrData[i];
      end
    end else begin : g_grp1
      assign clrVec[i] = strb.wrStat && strb.grp && wrData[i-GRP0_PINS];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) maskVec[i] <= 1'b1;
        else if (strb.wrMask && strb.grp) maskVec[i] <= wrData[i-GRP0_PINS];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statVec[i] <= 1'b0;
      else       statVec[i] <= (statVec[i] & ~clrVec[i]) | evtVec[i];
    end

    assign dirVec[i]            = driveReg[i][5];
    assign padOutVal[i]         = driveReg[i][0];
    assign padPullSel[2*i +: 2] = driveReg[i][2:1];
    assign padPullEn[i]         = driveReg[i][3];
    assign padPushPull[i]       = driveReg[i][4];
    assign padOutEn[i]          = driveReg[i][5] & (driveReg[i][4] | ~driveReg[i][0]);
  end

  assign irqOut = |(statVec & ~maskVec);

  always_comb begin
    case (strb.rdSel)
      SEL_DRIVE: rdMux = DW'(driveReg[strb.pin]);
      SEL_SENSE: rdMux = DW'({edgeMode[strb.pin], syncB[strb.pin]});
      SEL_STAT:  rdMux = strb.grp ? DW'(statVec[NUM_PINS-1:GRP0_PINS])
                                  : DW'(statVec[GRP0_PINS-1:0]);
      SEL_MASK:  rdMux = strb.grp ? DW'(maskVec[NUM_PINS-1:GRP0_PINS])
                                  : DW'(maskVec[GRP0_PINS-1:0]);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdMux;
  end
endmodule

// File: rtl/gpio_edge_irq_top.sv
module gpio_edge_irq_top
  import gpio_edge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [AW-1:0]         busAddr,
  input  logic [DW-1:0]         busWrData,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  output logic [DW-1:0]         busRdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   padOutVal,
  output logic [NUM_PINS-1:0]   padOutEn,
  output logic [NUM_PINS-1:0]   padPushPull,
  output logic [NUM_PINS-1:0]   padPullEn,
  output logic [2*NUM_PINS-1:0] padPullSel,
  output logic                  irqOut
);
  strobes_t strb;
  logic [NUM_PINS-1:0] statVec, maskVec, evtVec, clrVec, dirVec;

  gpio_edge_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  gpio_edge_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busWrData),
    .pinIn       (pinIn),
    .rdData      (busRdData),
    .irqOut      (irqOut),
    .padOutVal   (padOutVal),
    .padOutEn    (padOutEn),
    .padPushPull (padPushPull),
    .padPullEn   (padPullEn),
    .padPullSel  (padPullSel),
    .statVec     (statVec),
    .maskVec     (maskVec),
    .evtVec      (evtVec),
    .clrVec      (clrVec),
    .dirVec      (dirVec)
  );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic                busRdEn,
  input logic [DW-1:0]       busRdData,
  input logic                irqOut,
  input strobes_t            strb,
  input logic [NUM_PINS-1:0] statVec,
  input logic [NUM_PINS-1:0] maskVec,
  input logic [NUM_PINS-1:0] evtVec,
  input logic [NUM_PINS-1:0] clrVec,
  input logic [NUM_PINS-1:0] dirVec,
  input logic [NUM_PINS-1:0] padOutEn
);
  assert_oe_needs_dir_R3: assert property (@(posedge clk) disable iff (!rstN)
    (padOutEn & ~dirVec) == '0);

  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStat |=> ((statVec & $past(clrVec & ~evtVec)) == '0));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((statVec & $past(evtVec)) == $past(evtVec)));

  assert_all_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVec) |-> !irqOut);

  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !(strb.wrDrive || strb.wrSense || strb.wrStat || strb.wrMask))
      |=> ($stable(maskVec) && $stable(dirVec)));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));
endmodule

bind gpio_edge_irq_top gpio_edge_irq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .strb      (strb),
  .statVec   (statVec),
  .maskVec   (maskVec),
  .evtVec    (evtVec),
  .clrVec    (clrVec),
  .dirVec    (dirVec),
  .padOutEn  (padOutEn)
);

// File: tb/tb_gpio_edge_irq_top.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busRdData;
  logic [12:0] pinIn = '0;
  logic [12:0] padOutVal, padOutEn, padPushPull, padPullEn;
  logic [25:0] padPullSel;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .pinIn(pinIn), .padOutVal(padOutVal), .padOutEn(padOutEn),
    .padPushPull(padPushPull), .padPullEn(padPullEn),
    .padPullSel(padPullSel), .irqOut(irqOut)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic setPin(input int p, input logic v);
    @(negedge clk);
    pinIn[p] = v;
    waitCycles(5);
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 irqOut", irqOut, 0);
    check("R1 pads", {padOutVal, padOutEn, padPushPull, padPullEn} | 52'(padPullSel), 0);
    doRead(16'h4E19, d); check("R1 mask0", d, 8'h7F);
    doRead(16'h4E1A, d); check("R1 mask1", d, 8'h3F);
    doRead(16'h4E0B, d); check("R1 stat0", d, 0);
    doRead(16'h4E0C, d); check("R1 stat1", d, 0);
    doRead(16'h4E44, d); check("R1 drive0", d, 0);
    doRead(16'h4E5D, d); check("R1 sense12", d, 0);
  endtask

  task automatic testDrive();
    logic [7:0] d;
    doWrite(16'h4E47, 8'hFF);
    doRead(16'h4E47, d); check("R2 drive3 readback", d, 8'h3F);
    check("R3 outVal3", padOutVal[3], 1);
    check("R3 outEn3 push-pull", padOutEn[3], 1);
    check("R3 pushPull3", padPushPull[3], 1);
    check("R3 pullEn3", padPullEn[3], 1);
    check("R3 pullSel3", padPullSel[7:6], 3);
    doWrite(16'h4E49, 8'h21);
    check("R3 open-drain high releases", padOutEn[5], 0);
    doWrite(16'h4E49, 8'h20);
    check("R3 open-drain low drives", padOutEn[5], 1);
    doWrite(16'h4E49, 8'h14);
    check("R3 input dir no enable", padOutEn[5], 0);
    check("R3 pullSel5", padPullSel[11:10], 2);
  endtask

  task automatic testSense();
    logic [7:0] d;
    setPin(9, 1'b1);
    doRead(16'h4E5A, d); check("R4 level pin9", d, 8'h01);
    doWrite(16'h4E53, 8'hFD);
    doRead(16'h4E53, d); check("R4 sense2 bit0 ignored", d, 8'h04);
  endtask

  task automatic testEdges();
    logic [7:0] d;
    setPin(2, 1'b1);
    doRead(16'h4E0B, d); check("R5 R6 rising pin2", d, 8'h04);
    doWrite(16'h4E0B, 8'h04);
    setPin(2, 1'b0);
    doRead(16'h4E0B, d); check("R5 rising mode ignores fall", d, 0);
    doWrite(16'h4E59, 8'h02);
    setPin(8, 1'b1);
    doRead(16'h4E0C, d); check("R5 falling mode ignores rise", d, 0);
    setPin(8, 1'b0);
    doRead(16'h4E0C, d); check("R5 R6 falling pin8", d, 8'h02);
    doWrite(16'h4E0C, 8'h02);
    doWrite(16'h4E5D, 8'h06);
    setPin(12, 1'b1);
    doRead(16'h4E0C, d); check("R5 R6 both rise pin12", d, 8'h20);
    doWrite(16'h4E0C, 8'h00);
    doRead(16'h4E0C, d); check("R7 write 0 keeps", d, 8'h20);
    doWrite(16'h4E0C, 8'h20);
    doRead(16'h4E0C, d); check("R7 write 1 clears", d, 0);
    setPin(12, 1'b0);
    doRead(16'h4E0C, d); check("R7 re-set after clear", d, 8'h20);
    doWrite(16'h4E0C, 8'h20);
    setPin(0, 1'b1);
    setPin(0, 1'b0);
    doRead(16'h4E0B, d); check("R5 mode 0 no event", d, 0);
  endtask

  task automatic testCollision();
    logic [7:0] d;
    doWrite(16'h4E55, 8'h06);
    setPin(4, 1'b1);
    doRead(16'h4E0B, d); check("R8 setup pending", d, 8'h10);
    @(negedge clk); pinIn[4] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busAddr = 16'h4E0B; busWrData = 8'h10; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    doRead(16'h4E0B, d); check("R8 event beats clear", d, 8'h10);
    doWrite(16'h4E0B, 8'h10);
    doRead(16'h4E0B, d); check("R7 clear after collision", d, 0);
  endtask

  task automatic testIrq();
    logic [7:0] d;
    doWrite(16'h4E5B, 8'h04);
    setPin(10, 1'b1);
    doRead(16'h4E0C, d); check("R6 pin10 group1 bit3", d, 8'h08);
    check("R9 masked no irq", irqOut, 0);
    doWrite(16'h4E1A, 8'h37);
    check("R9 unmasked irq", irqOut, 1);
    doWrite(16'h4E0C, 8'h08);
    check("R9 irq drops after clear", irqOut, 0);
    doRead(16'h4E1A, d); check("R9 mask1 readback", d, 8'h37);
  endtask

  task automatic testUnmapped();
    logic [7:0] d;
    doWrite(16'h4E5E, 8'hFF);
    doWrite(16'h4E43, 8'hFF);
    doWrite(16'h4E0D, 8'hFF);
    doWrite(16'h4E1B, 8'h00);
    doRead(16'h4E5E, d); check("R10 read 0x4E5E", d, 0);
    doRead(16'h4E43, d); check("R10 read 0x4E43", d, 0);
    doRead(16'h4E19, d); check("R10 mask0 untouched", d, 8'h7F);
    doRead(16'h4E50, d); check("R10 drive12 untouched", d, 0);
  endtask

  task automatic testReadHold();
    logic [7:0] d;
    doRead(16'h4E47, d);
    waitCycles(3);
    check("R11 read data holds", busRdData, 8'h3F);
  endtask

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    testReset();
    testDrive();
    testSense();
    testEdges();
    testCollision();
    testIrq();
    testUnmapped();
    testReadHold();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule